// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer

This block decides which of four sampled analog channels (A, B, C, D) the single shared converter takes in each conversion slot. A conversion slot is one clock cycle in which `conv_en` is high. The caller sets the sequence length with a channel-count mode: 4, 3, 2 or 1 channels.

- In 4-channel mode a direction bit picks forward or reversed order.
- In 1-channel mode a one-hot selection field pins the multiplexer to a single channel.

A pixel-start strobe, derived from the data-level sample clock, restarts the sequence at the first channel of the selected order. The block flags a strobe that arrives before the current pixel's channels have all been converted.

The outputs form a registered, valid-only stream. For each slot the block presents a channel code, a first-of-pixel marker and the valid bit. There is no ready input, because the converter takes every slot; back-pressure is not possible, and a slot with `conv_en` low simply produces no beat. Channel codes are A=0, B=1, C=2, D=3.

Top module: `conv_chan_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `conv_vld`, `ch_sel`, `first_of_pixel` and `overrun` are all 0. The sequence position returns to its first entry.
- R2: In 4-channel mode (`chan_mode`=2'b11) with `order_rev`=0, successive slots select A, B, C, D (codes 0,1,2,3) and then wrap. Each result appears on the outputs one clock after the edge that samples `conv_en` high.
- R3: In 4-channel mode with `order_rev`=1, successive slots select D, C, B, A (codes 3,2,1,0).
- R4: In 3-channel mode (`chan_mode`=2'b10), successive slots select A, B, C and then wrap. `order_rev` has no effect.
- R5: In 2-channel mode (`chan_mode`=2'b01), successive slots select A, B and then wrap.
- R6: In 1-channel mode (`chan_mode`=2'b00) the selection does not advance. It follows `single_sel`: bit 3 selects A, bit 2 selects B, bit 1 selects C, bit 0 selects D.
- R7: In 1-channel mode, when several `single_sel` bits are set, the channel nearest A wins. When none is set, A is selected.
- R8: A `pix_strobe` cycle restarts the sequence. A slot in that same cycle, or the first slot after it, takes the first channel of the selected order.
- R9: If `pix_strobe` arrives while a pixel is partly converted (at least one channel of it done and not all), `overrun` is high for the one cycle after that strobe. A strobe on a pixel boundary, or in 1-channel mode, gives no overrun.
- R10: `first_of_pixel` is high only on a valid beat that holds the first channel of the order. It is low whenever `conv_vld` is low.
- R11: A cycle with `conv_en` low yields `conv_vld`=0 on the next cycle. That cycle leaves the sequence position and the last `ch_sel` value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_en | input | 1 | Conversion slot in this cycle |
| pix_strobe | input | 1 | Pixel-start pulse; restarts the sequence |
| chan_mode | input | 2 | 00=1 ch, 01=2 ch, 10=3 ch, 11=4 ch |
| order_rev | input | 1 | 4-channel order reversed when 1 |
| single_sel | input | 4 | One-hot stationary select, bit 3 = A .. bit 0 = D |
| conv_vld | output | 1 | Beat valid: a conversion slot took place |
| ch_sel | output | 2 | Channel for the beat, A=0 .. D=3 |
| first_of_pixel | output | 1 | Beat carries the first channel of the order |
| overrun | output | 1 | Previous cycle's strobe cut a pixel short |

## Verification
The stimulus table runs each mode in turn.

- **4-channel mode:** forward order with an idle slot in the middle, which separates "advance per slot" from "advance per clock". Then reversed order, which separates direction from mode.
- **3-channel mode:** run with the reverse bit set, to show that the bit is ignored there.
- **2-channel mode:** rotation and restart behaviour.
- **Strobe placement:** strobes land both mid-pixel and on boundaries, with and without a coincident slot. This separates a restart that warns (`overrun`) from one that does not.
- **1-channel mode:** every single one-hot code, then multi-bit and empty codes, which expose the priority order.
- **Directed tests:** a reset taken mid-pixel, checked to return the sequence to its first channel.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
  localparam int NUM_CH = 4;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int LEN_W  = CH_W + 1;

  typedef logic [CH_W-1:0]  ch_idx_t;
  typedef logic [LEN_W-1:0] grp_len_t;

  typedef enum logic [CH_W-1:0] {
    MODE_1CH = 2'd0,
    MODE_2CH = 2'd1,
    MODE_3CH = 2'd2,
    MODE_4CH = 2'd3
  } ch_mode_e;

  // channels in one pixel group for a given mode
  function automatic grp_len_t group_len(input ch_mode_e m);
    return {1'b0, m} + grp_len_t'(1);
  endfunction
endpackage

// File: rtl/seq_pos_ctr.sv
module seq_pos_ctr
  import conv_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     step,
  input  logic     restart,
  input  grp_len_t len,
  output ch_idx_t  eff_pos,
  output logic     cut_short
);
  ch_idx_t  pos_q;
  grp_len_t pos_ext;
  grp_len_t nxt_ext;

  assign pos_ext = {1'b0, pos_q};

  // a stale position beyond the current group length counts as the start
  always_comb begin
    if (restart || (pos_ext >= len)) eff_pos = '0;
    else                             eff_pos = pos_q;
  end

  assign nxt_ext   = {1'b0, eff_pos} + grp_len_t'(1);
  assign cut_short = restart && (pos_q != '0) && (pos_ext < len);

  always_ff @(posedge clk) begin
    if (!rst_n)            pos_q <= '0;
    else if (step)         pos_q <= (nxt_ext == len) ? '0 : nxt_ext[CH_W-1:0];
    else                   pos_q <= eff_pos;
  end
endmodule

// File: rtl/seq_chan_map.sv
module seq_chan_map
  import conv_seq_pkg::*;
(
  input  ch_mode_e          mode,
  input  logic              rev,
  input  logic [NUM_CH-1:0] one_hot,
  input  ch_idx_t           pos,
  output ch_idx_t           chan
);
  ch_idx_t pinned;

  // later iterations override earlier ones, so the bit for A wins
  always_comb begin
    pinned = '0;
    for (int k = 0; k < NUM_CH; k++) begin
      if (one_hot[k]) pinned = ch_idx_t'(NUM_CH - 1 - k);
    end
  end

  always_comb begin
    unique case (mode)
      MODE_1CH: chan = pinned;
      MODE_4CH: chan = rev ? ch_idx_t'(NUM_CH - 1) - pos : pos;
      default:  chan = pos;
    endcase
  end
endmodule

// File: rtl/conv_chan_sequencer.sv
module conv_chan_sequencer
  import conv_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_en,
  input  logic              pix_strobe,
  input  logic [CH_W-1:0]   chan_mode,
  input  logic              order_rev,
  input  logic [NUM_CH-1:0] single_sel,
  output logic              conv_vld,
  output logic [CH_W-1:0]   ch_sel,
  output logic              first_of_pixel,
  output logic              overrun
);
  ch_mode_e mode;
  ch_idx_t  eff_pos;
  ch_idx_t  chan;
  logic     cut_short;

  assign mode = ch_mode_e'(chan_mode);

  seq_pos_ctr u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (conv_en),
    .restart   (pix_strobe),
    .len       (group_len(mode)),
    .eff_pos   (eff_pos),
    .cut_short (cut_short)
  );

  seq_chan_map u_map (
    .mode    (mode),
    .rev     (order_rev),
    .one_hot (single_sel),
    .pos     (eff_pos),
    .chan    (chan)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conv_vld       <= 1'b0;
      ch_sel         <= '0;
      first_of_pixel <= 1'b0;
      overrun        <= 1'b0;
    end else begin
      conv_vld       <= conv_en;
      first_of_pixel <= conv_en && (eff_pos == '0);
      overrun        <= cut_short;
      if (conv_en) ch_sel <= chan;
    end
  end
endmodule

// File: rtl/conv_seq_checker.sv
module conv_seq_checker
  import conv_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              conv_en,
  input logic              pix_strobe,
  input logic [CH_W-1:0]   chan_mode,
  input logic              order_rev,
  input logic [NUM_CH-1:0] single_sel,
  input logic              conv_vld,
  input logic [CH_W-1:0]   ch_sel,
  input logic              first_of_pixel,
  input logic              overrun
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!conv_vld && !overrun && !first_of_pixel)); // R1

  AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_vld && ch_sel == 2'd0 && conv_en && !pix_strobe && chan_mode == 2'd3
     && !order_rev && $stable(chan_mode) && $stable(order_rev)) |=> (ch_sel == 2'd1)); // R2

  AST_THREE_NO_D: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_vld && $past(chan_mode) == 2'd2) |-> (ch_sel != 2'd3)); // R4

  AST_TWO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_vld && $past(chan_mode) == 2'd1) |-> (ch_sel <= 2'd1)); // R5

  AST_SINGLE_A: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_mode == 2'd0 && conv_en && single_sel == 4'b1000) |=> (conv_vld && ch_sel == 2'd0)); // R6

  AST_STROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && conv_en) |=> first_of_pixel); // R8

  AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(pix_strobe)); // R9

  AST_FIRST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    first_of_pixel |-> conv_vld); // R10

  AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> (!conv_vld && $stable(ch_sel))); // R11
endmodule

bind conv_chan_sequencer conv_seq_checker i_conv_seq_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .conv_en        (conv_en),
  .pix_strobe     (pix_strobe),
  .chan_mode      (chan_mode),
  .order_rev      (order_rev),
  .single_sel     (single_sel),
  .conv_vld       (conv_vld),
  .ch_sel         (ch_sel),
  .first_of_pixel (first_of_pixel),
  .overrun        (overrun)
);

// File: tb/test_conv_chan_sequencer.sv
`timescale 1ns/1ps
module test_conv_chan_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       conv_en = 1'b0;
  logic       pix_strobe = 1'b0;
  logic [1:0] chan_mode = 2'd3;
  logic       order_rev = 1'b0;
  logic [3:0] single_sel = 4'b0000;
  logic       conv_vld;
  logic [1:0] ch_sel;
  logic       first_of_pixel;
  logic       overrun;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  conv_chan_sequencer i_conv_chan_sequencer (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .pix_strobe(pix_strobe),
    .chan_mode(chan_mode), .order_rev(order_rev), .single_sel(single_sel),
    .conv_vld(conv_vld), .ch_sel(ch_sel), .first_of_pixel(first_of_pixel),
    .overrun(overrun)
  );

  // {strobe, en, mode[1:0], rev, sel[3:0], exp_vld, exp_ch[1:0], exp_first, exp_ovr}
  localparam int NV = 32;
  localparam logic [13:0] VEC [0:NV-1] = '{
    14'b1_1_11_0_0000_1_00_1_0, // R2 R8 start 4ch fwd: A
    14'b0_1_11_0_0000_1_01_0_0, // R2 B
    14'b0_0_11_0_0000_0_01_0_0, // R11 idle holds
    14'b0_1_11_0_0000_1_10_0_0, // R2 C
    14'b0_1_11_0_0000_1_11_0_0, // R2 D
    14'b0_1_11_0_0000_1_00_1_0, // R2 R10 wrap to A
    14'b1_1_11_0_0000_1_00_1_1, // R9 mid-pixel strobe
    14'b1_0_11_0_0000_0_00_0_1, // R9 R10 strobe, no slot
    14'b1_1_11_0_0000_1_00_1_0, // R9 boundary strobe, no overrun
    14'b1_1_11_1_0000_1_11_1_1, // R3 R9 reversed: D
    14'b0_1_11_1_0000_1_10_0_0, // R3 C
    14'b0_1_11_1_0000_1_01_0_0, // R3 B
    14'b0_1_11_1_0000_1_00_0_0, // R3 A
    14'b1_1_11_1_0000_1_11_1_0, // R3 R8 restart at D
    14'b1_1_10_1_0000_1_00_1_1, // R4 3ch, rev ignored
    14'b0_1_10_1_0000_1_01_0_0, // R4
    14'b0_1_10_1_0000_1_10_0_0, // R4
    14'b0_1_10_1_0000_1_00_1_0, // R4 wrap
    14'b1_0_10_1_0000_0_00_0_1, // R9 R11
    14'b1_1_01_0_0000_1_00_1_0, // R5 2ch
    14'b0_1_01_0_0000_1_01_0_0, // R5
    14'b1_1_01_0_0000_1_00_1_0, // R5 R8
    14'b0_1_00_0_1000_1_00_1_0, // R6 A
    14'b0_1_00_0_0100_1_01_1_0, // R6 B
    14'b0_1_00_0_0010_1_10_1_0, // R6 C
    14'b0_1_00_0_0001_1_11_1_0, // R6 D
    14'b1_1_00_0_0001_1_11_1_0, // R9 no overrun in 1ch
    14'b0_1_00_0_0110_1_01_1_0, // R7 B over C
    14'b0_1_00_0_0011_1_10_1_0, // R7 C over D
    14'b0_1_00_0_0000_1_00_1_0, // R7 none -> A
    14'b0_1_00_0_1111_1_00_1_0, // R7 all -> A
    14'b0_0_00_0_0001_0_00_0_0  // R11 idle
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic v, input logic [1:0] c,
                           input logic f, input logic o);
    chk({req, " vld"}, int'(conv_vld), int'(v));
    chk({req, " ch"}, int'(ch_sel), int'(c));
    chk({req, " first"}, int'(first_of_pixel), int'(f));
    chk({req, " ovr"}, int'(overrun), int'(o));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R1 reset", 1'b0, 2'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 post-release", 1'b0, 2'd0, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      pix_strobe = VEC[i][13];
      conv_en    = VEC[i][12];
      chan_mode  = VEC[i][11:10];
      order_rev  = VEC[i][9];
      single_sel = VEC[i][8:5];
      @(negedge clk);
      check_all($sformatf("vector %0d", i), VEC[i][4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end

    // directed: reset taken mid-pixel returns the sequence to A
    chan_mode = 2'd3; order_rev = 1'b0; pix_strobe = 1'b1; conv_en = 1'b1;
    @(negedge clk);
    pix_strobe = 1'b0;
    @(negedge clk);
    check_all("R2 pre-reset B", 1'b1, 2'd1, 1'b0, 1'b0);
    rst_n = 1'b0; conv_en = 1'b0;
    @(negedge clk);
    check_all("R1 mid-run reset", 1'b0, 2'd0, 1'b0, 1'b0);
    rst_n = 1'b1; conv_en = 1'b1;
    @(negedge clk);
    check_all("R1 R8 restart after reset", 1'b1, 2'd0, 1'b1, 1'b0);

    // directed: strobe while idle mid-pixel, then slot takes first of reversed order
    order_rev = 1'b1; pix_strobe = 1'b1; conv_en = 1'b0;
    @(negedge clk);
    check_all("R9 idle strobe cuts pixel", 1'b0, 2'd0, 1'b0, 1'b1);
    pix_strobe = 1'b0; conv_en = 1'b1;
    @(negedge clk);
    check_all("R3 R8 first after strobe", 1'b1, 2'd3, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule